// File: doc/BRIEF.md
# Inverter Pre-Pass Analyzer

This block inspects the complete truth table of an n-wire reversible function before that function is broken into gates. It decides whether inverting some output wires would leave fewer table rows to fix. The table is streamed in one row per cycle, in ascending input order. Each row carries its input index and the output vector that the function produces for that index.

While the rows arrive, the block does three things. It keeps one mismatch count per wire, where a mismatch is a row in which that output bit differs from the same bit of the index. It counts the rows whose output differs from the index in any bit. It also stores the rows. A wire becomes a candidate for inversion when its mismatch count is strictly above half the row count. The inverters sit after the function, so the modified output is the original output XOR the candidate mask.

Because the candidate mask is only known once every row is in, the block then runs a second pass on its own. It reads the stored rows back and counts the rows that still differ from their index once the mask is applied. It adopts the candidate mask only when this masked count is strictly smaller than the unmasked one, and otherwise reports a zero mask. Both counts, the chosen mask and a one-cycle done pulse come out at the end. The table does not have to be a bijection; any table is analysed the same way.

Top module: `ipp_analyzer`

## Requirements
- R1: For each output wire b, the block counts over all 2^n rows how many rows have output bit b different from index bit b.
- R2: Wire b is an inversion candidate exactly when its mismatch count is strictly greater than 2^(n-1). A count equal to 2^(n-1) does not qualify.
- R3: `raw_cnt_o` reports the number of rows whose output vector differs from the row index in at least one bit.
- R4: `masked_cnt_o` reports the number of rows for which (output XOR candidate mask) differs from the row index. This value is reported even when the mask is not adopted.
- R5: `mask_o` equals the candidate mask when `masked_cnt_o` < `raw_cnt_o`. Otherwise it is all zeros, including the case where the two counts are equal.
- R6: `done_o` is high for exactly one cycle. It rises 2^n+1 clock edges after the edge that accepts the final row (index 2^n-1). All result outputs hold their values until the next done pulse.
- R7: The counts are n+1 bits wide, so a value of 2^n is reported without overflow. For example, a table whose every output is the bitwise complement of its index gives `raw_cnt_o` = 2^n.
- R8: A valid row whose index is not the next expected one is dropped, so it is neither stored nor counted. `seq_err_o` is high in the cycle after it, and the expected index is unchanged.
- R9: A valid row presented while the second pass is running is dropped and flagged on `seq_err_o` in the cycle after it. It does not affect the results.
- R10: After reset, `done_o`, `seq_err_o`, `mask_o` and both counts are zero, and the block expects index 0.
- R11: After a done pulse the block accepts a new table starting again from index 0. All counts start from zero for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid_i | input | 1 | A table row is presented this cycle |
| row_idx_i | input | W | Input index of the row |
| row_out_i | input | W | Output vector of the function for that index |
| done_o | output | 1 | One-cycle pulse: results updated |
| seq_err_o | output | 1 | A row was dropped in the previous cycle |
| mask_o | output | W | Adopted inversion mask, zero if inverters do not help |
| raw_cnt_o | output | W+1 | Rows differing from their index, unmasked |
| masked_cnt_o | output | W+1 | Rows differing from their index with the candidate mask applied |

## Verification
The second pass and the error path can meet in one cycle. A row presented while the stored table is being read back must be rejected and flagged, and it must not disturb the masked count that is being built in that same cycle. The bench provokes this by driving a valid row directly after the final row has been accepted. It then checks that `seq_err_o` rises one cycle later, that the done pulse still arrives exactly 2^n+1 edges after the last row, and that all counts still match the model computed from the clean table. A dropped out-of-order row in the middle of the first pass is judged the same way.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_SCAN = 2'd1,
      ST_FIN  = 2'd2
   } ipp_state_e;
endpackage

// File: rtl/ipp_bit_counters.sv
module ipp_bit_counters #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] diff,
   output logic [W-1:0] inv_o
);
   localparam int CW = W + 1;
   localparam logic [CW-1:0] HALF = CW'(1) << (W - 1);

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt <= '0;
         else if (clr)            cnt <= '0;
         else if (en && diff[b])  cnt <= cnt + 1'b1;
      end
      assign inv_o[b] = (cnt > HALF);
   end
endmodule

// File: rtl/ipp_row_counter.sv
module ipp_row_counter #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          hit,
   output logic [CW-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_o <= '0;
      else if (clr)        cnt_o <= '0;
      else if (en && hit)  cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/ipp_row_store.sv
module ipp_row_store #(
   parameter int W     = 4,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         we,
   input  logic [W-1:0] waddr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] raddr,
   output logic [W-1:0] rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
   assign rdata = mem[raddr];
endmodule

// File: rtl/ipp_analyzer.sv
module ipp_analyzer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         row_valid_i,
   input  logic [W-1:0] row_idx_i,
   input  logic [W-1:0] row_out_i,
   output logic         done_o,
   output logic         seq_err_o,
   output logic [W-1:0] mask_o,
   output logic [W:0]   raw_cnt_o,
   output logic [W:0]   masked_cnt_o
);
   import ipp_pkg::*;

   localparam int CW = W + 1;
   localparam int DEPTH = 1 << W;
   localparam logic [W-1:0] LAST = W'(DEPTH - 1);

   if (W < 2 || W > 10) begin : g_bad_width
      $error("ipp_analyzer: W must lie in 2..10");
   end

   ipp_state_e    state;
   logic [W-1:0]  exp_idx;
   logic [W-1:0]  scan_idx;
   logic          accept;
   logic          clr;
   logic          scanning;
   logic [W-1:0]  cand;
   logic [W-1:0]  rd_out;
   logic [CW-1:0] raw_cnt;
   logic [CW-1:0] msk_cnt;

   assign accept   = row_valid_i && (state == ST_LOAD) && (row_idx_i == exp_idx);
   assign clr      = (state == ST_FIN);
   assign scanning = (state == ST_SCAN);

   ipp_bit_counters #(.W(W)) i_bits (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(accept),
      .diff(row_out_i ^ row_idx_i), .inv_o(cand)
   );

   ipp_row_counter #(.CW(CW)) i_raw (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(accept),
      .hit(row_out_i != row_idx_i), .cnt_o(raw_cnt)
   );

   ipp_row_store #(.W(W), .DEPTH(DEPTH)) i_store (
      .clk(clk), .we(accept), .waddr(row_idx_i), .wdata(row_out_i),
      .raddr(scan_idx), .rdata(rd_out)
   );

   ipp_row_counter #(.CW(CW)) i_msk (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(scanning),
      .hit((rd_out ^ cand) != scan_idx), .cnt_o(msk_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_LOAD;
         exp_idx  <= '0;
         scan_idx <= '0;
      end else begin
         case (state)
            ST_LOAD: if (accept) begin
               exp_idx <= exp_idx + 1'b1;
               if (row_idx_i == LAST) begin
                  state    <= ST_SCAN;
                  scan_idx <= '0;
               end
            end
            ST_SCAN: begin
               scan_idx <= scan_idx + 1'b1;
               if (scan_idx == LAST) state <= ST_FIN;
            end
            default: state <= ST_LOAD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o       <= 1'b0;
         seq_err_o    <= 1'b0;
         mask_o       <= '0;
         raw_cnt_o    <= '0;
         masked_cnt_o <= '0;
      end else begin
         seq_err_o <= row_valid_i && !accept;
         done_o    <= clr;
         if (clr) begin
            raw_cnt_o    <= raw_cnt;
            masked_cnt_o <= msk_cnt;
            mask_o       <= (msk_cnt < raw_cnt) ? cand : '0;
         end
      end
   end
endmodule

// File: rtl/ipp_analyzer_chk.sv
module ipp_analyzer_chk #(
   parameter int W = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         done_o,
   input logic         seq_err_o,
   input logic [W-1:0] mask_o,
   input logic [W:0]   raw_cnt_o,
   input logic [W:0]   masked_cnt_o,
   input logic         row_valid_i,
   input logic         accept
);
   localparam int DEPTH = 1 << W;

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_hold_results_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(mask_o) && $stable(raw_cnt_o) && $stable(masked_cnt_o)));

   p_mask_only_if_better_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (masked_cnt_o >= raw_cnt_o)) |-> (mask_o == '0));

   p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((raw_cnt_o <= (W+1)'(DEPTH)) && (masked_cnt_o <= (W+1)'(DEPTH))));

   p_drop_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid_i && !accept) |=> seq_err_o);

   p_no_false_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_valid_i || accept) |=> !seq_err_o);
endmodule

bind ipp_analyzer ipp_analyzer_chk #(.W(W)) i_chk (
   .clk(clk), .rst_n(rst_n), .done_o(done_o), .seq_err_o(seq_err_o),
   .mask_o(mask_o), .raw_cnt_o(raw_cnt_o), .masked_cnt_o(masked_cnt_o),
   .row_valid_i(row_valid_i), .accept(accept)
);

// File: tb/test_ipp_analyzer.sv
module test_ipp_analyzer;
   localparam int W = 4;
   localparam int DEPTH = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         row_valid_i = 1'b0;
   logic [W-1:0] row_idx_i = '0;
   logic [W-1:0] row_out_i = '0;
   logic         done_o, seq_err_o;
   logic [W-1:0] mask_o;
   logic [W:0]   raw_cnt_o, masked_cnt_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   logic [W-1:0] tbl [DEPTH];

   always #4 clk = ~clk;

   ipp_analyzer #(.W(W)) i_ipp_analyzer (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Model built from the requirements
   task automatic model(output int e_mask, output int e_raw, output int e_msk);
      int cnt;
      logic [W-1:0] cand;
      cand = '0;
      for (int b = 0; b < W; b++) begin
         cnt = 0;
         for (int i = 0; i < DEPTH; i++) if (tbl[i][b] != i[b]) cnt++;
         cand[b] = (cnt > DEPTH / 2);
      end
      e_raw = 0; e_msk = 0;
      for (int i = 0; i < DEPTH; i++) begin
         if (tbl[i] != W'(i)) e_raw++;
         if ((tbl[i] ^ cand) != W'(i)) e_msk++;
      end
      e_mask = (e_msk < e_raw) ? int'(cand) : 0;
   endtask

   task automatic drive_row(input int idx, input logic [W-1:0] val);
      row_valid_i = 1'b1;
      row_idx_i   = W'(idx);
      row_out_i   = val;
      @(negedge clk);
   endtask

   task automatic drive_from(input int first);
      for (int i = first; i < DEPTH; i++) drive_row(i, tbl[i]);
      row_valid_i = 1'b0;
   endtask

   task automatic finish_check(input string tag, input bit intrude);
      int k, e_mask, e_raw, e_msk;
      logic [W-1:0] held;
      k = 1;
      if (intrude) begin
         drive_row(0, 4'h5);
         row_valid_i = 1'b0;
         k++;
         chk(seq_err_o == 1'b1, "R9 row during second pass flagged", seq_err_o, 1);
      end
      while (!done_o && k < DEPTH + 20) begin
         @(negedge clk);
         k++;
      end
      model(e_mask, e_raw, e_msk);
      chk(k == DEPTH + 2, {"R6 done latency ", tag}, k, DEPTH + 2);
      chk(raw_cnt_o == (W+1)'(e_raw), {"R3 raw count ", tag}, raw_cnt_o, e_raw);
      chk(masked_cnt_o == (W+1)'(e_msk), {"R4 masked count ", tag}, masked_cnt_o, e_msk);
      chk(mask_o == W'(e_mask), {"R5 R2 R1 mask ", tag}, mask_o, e_mask);
      held = mask_o;
      @(negedge clk);
      chk(done_o == 1'b0, {"R6 done one cycle ", tag}, done_o, 0);
      chk(mask_o == held, {"R6 mask held ", tag}, mask_o, held);
   endtask

   task automatic rand_perm(input logic [W-1:0] post);
      int j;
      logic [W-1:0] t;
      for (int i = 0; i < DEPTH; i++) tbl[i] = W'(i);
      for (int i = DEPTH - 1; i > 0; i--) begin
         j = $urandom % (i + 1);
         t = tbl[i]; tbl[i] = tbl[j]; tbl[j] = t;
      end
      for (int i = 0; i < DEPTH; i++) tbl[i] = tbl[i] ^ post;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(done_o == 0 && seq_err_o == 0, "R10 reset flags", {done_o, seq_err_o}, 0);
      chk(mask_o == 0 && raw_cnt_o == 0 && masked_cnt_o == 0, "R10 reset results",
          int'(mask_o) + int'(raw_cnt_o) + int'(masked_cnt_o), 0);

      // identity: counts zero, tie -> zero mask (R5)
      for (int i = 0; i < DEPTH; i++) tbl[i] = W'(i);
      drive_from(0); finish_check("identity", 0);

      // full complement: count of 2^n (R7), all wires inverted (R2)
      for (int i = 0; i < DEPTH; i++) tbl[i] = ~W'(i);
      drive_from(0); finish_check("complement R7", 0);
      chk(raw_cnt_o == (W+1)'(DEPTH), "R7 count reaches 2^n", raw_cnt_o, DEPTH);

      // exactly half on wire 0: not inverted (R2 threshold)
      for (int i = 0; i < DEPTH; i++) tbl[i] = ~W'(i) ^ W'(((i >> 1) & 1) ^ 1);
      drive_from(0); finish_check("half threshold R2", 0);
      chk(mask_o == 4'he, "R2 strict threshold mask", mask_o, 14);

      // tie: candidate nonzero but counts equal (R5)
      for (int i = 0; i < DEPTH; i++)
         tbl[i] = W'(i) ^ W'(i < 9) ^ (W'(i < 2) << 1);
      drive_from(0); finish_check("tie R5", 0);
      chk(mask_o == 0, "R5 tie gives zero mask", mask_o, 0);
      chk(masked_cnt_o == raw_cnt_o, "R4 tie counts equal", masked_cnt_o, raw_cnt_o);

      // out-of-sequence row dropped mid-table (R8)
      rand_perm(4'h0);
      drive_row(0, tbl[0]);
      drive_row(5, 4'h3);
      chk(seq_err_o == 1'b1, "R8 out-of-order flagged", seq_err_o, 1);
      drive_from(1);
      chk(seq_err_o == 1'b0, "R8 no flag on good row", seq_err_o, 0);
      finish_check("bad index R8", 0);

      // row during second pass (R9), then new table from index 0 (R11)
      rand_perm(4'h6);
      drive_from(0); finish_check("intrude R9", 1);
      rand_perm(4'h0);
      drive_from(0); finish_check("back-to-back R11", 0);

      // random tables, some shifted toward inversion
      for (int r = 0; r < 8; r++) begin
         rand_perm((r % 2 == 1) ? W'($urandom) : W'(0));
         drive_from(0); finish_check("random R1", 0);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule